// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 32-bit interval timer that software drives through four word registers on a simple single-cycle bus. The registers are control, reload period, prescale and live count. Counting needs two control bits, a power bit and a run bit, and both must be set. The timer does not count while either bit is clear, so software can program it in that state. A prescaler divides the clock by the prescale value plus one. Each time the prescaler wraps, the live count drops by one.

When the count reaches zero, the timer expires. Expiry sets a sticky flag in the control register, and the interrupt request output follows that flag. If auto-reload is selected, the count is reloaded from the period register and counting goes on. If auto-reload is not selected, the count stays at zero and the timer clears its own run bit. Software clears the flag by writing a one to it.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset all four registers read zero and `irq` is low.
- R2: Word registers are selected by byte address: control 0x0, period 0x4, prescale 0x8, count 0xC. An access whose address bits [1:0] are not zero writes nothing and reads zero. Period, prescale and count read back the value last written.
- R3: The count changes only while control bit 0 (power) and control bit 1 (run) are both set. Otherwise it holds its value.
- R4: With prescale value S, the count decrements once every S+1 clocks. The first decrement lands on the (S+1)-th clock edge after the write that enables counting.
- R5: The prescaler restarts from zero whenever counting is disabled, so a restart gives the full S+1 clocks before the first decrement.
- R6: A decrement step that starts with a count of 1 or 0 is an expiry. It sets control bit 3 (the flag). `irq` equals the flag.
- R7: With control bit 2 (auto-reload) set, an expiry loads the count from the period register and the timer keeps running.
- R8: With auto-reload clear, an expiry leaves the count at zero and clears the run bit. The power bit keeps its value.
- R9: The flag is cleared by writing 1 to control bit 3. Writing 0 to bit 3 leaves it unchanged.
- R10: Writing zero to the control register stops the timer. The count keeps its value after that.
- R11: A bus write to the count register takes priority over a decrement in the same clock, and it preloads the count independently of the period.
- R12: The control register reads {28 zero bits, flag, auto-reload, run, power}, with power in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq | output | 1 | Interrupt request, equal to the sticky flag |

## Verification
On every cycle, the assertions check four things:
- the count holds while the timer is idle;
- the count steps down by exactly one per prescaler wrap;
- an expiry reloads the period or clears the run bit, and always sets the flag;
- the flag stays set until it is written with a one.

The exact number of clocks between enabling the timer and each decrement or expiry can only be shown by the bench's scenarios. The same holds for the prescaler restart after a stop, the priority of a count write over a decrement, and the read-back encoding of the control word.

// File: rtl/tmr_pkg.sv
// Shared constants for the prescaled interval timer.
// Assumes word registers on a byte address whose bits [3:2] pick the register.
package tmr_pkg;
    localparam int CTL_PWR  = 0;
    localparam int CTL_RUN  = 1;
    localparam int CTL_AUTO = 2;
    localparam int CTL_FLAG = 3;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Clock divider for the timer: raises tick_o once every scale_i+1 clocks while
// active_i is high. It holds its counter at zero while inactive, so a restart
// always waits the full interval. A scale value lowered below the running
// count ticks at once.
module tmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic [W-1:0] scale_i,
    output logic         tick_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] div_q;

    // Tick when the divider has reached the programmed terminal value.
    assign tick_o = active_i && (div_q >= scale_i);

    // Advance the divider, wrap on tick, and clear it while counting is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + ONE;
        end
    end

    // R5: an idle cycle leaves the divider at zero.
    p_idle_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (div_q == '0));
endmodule

// File: rtl/tmr_downcount.sv
// Live count register of the timer. It steps down on each prescaler tick. On
// a tick that starts from 1 or 0 it reports an expiry and either reloads the
// period or parks at zero. A bus load takes priority over the tick. Ticks are
// assumed to come only while the timer is active.
module tmr_downcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] period_i,
    input  logic         autold_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_q;

    // Expiry: a tick that would bring the count to zero (or finds it there).
    assign expire_o = tick_i && !load_i && (count_q <= ONE);
    assign count_o  = count_q;

    // Load, reload, park or decrement the live count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (expire_o) begin
            count_q <= autold_i ? period_i : '0;
        end else if (tick_i) begin
            count_q <= count_q - ONE;
        end
    end

    // R3: no tick and no load means the count holds.
    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_q));

    // R4: an ordinary tick takes exactly one off the count.
    p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && (count_q > ONE)) |=> (count_q == $past(count_q) - ONE));

    // R7: with auto-reload, expiry copies the period.
    p_reload_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && autold_i) |=> (count_q == $past(period_i)));

    // R8: without auto-reload, expiry parks the count at zero.
    p_park_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !autold_i) |=> (count_q == '0));
endmodule

// File: rtl/tmr_control.sv
// Control word of the timer: power, run and auto-reload bits plus the sticky
// expiry flag. A bus write sets the three mode bits and clears the flag where
// bit 3 of the written data is one. An expiry sets the flag, and without
// auto-reload it also drops the run bit. A bus write to run beats that drop
// in the same cycle. An expiry beats a flag clear in the same cycle.
module tmr_control (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [3:0] wdata_i,
    input  logic       expire_i,
    output logic       pwr_o,
    output logic       run_o,
    output logic       autold_o,
    output logic       flag_o
);
    import tmr_pkg::*;

    logic pwr_q, run_q, auto_q, flag_q;

    // Mode bits: written by the bus; run self-clears on a one-shot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= 1'b0;
            run_q  <= 1'b0;
            auto_q <= 1'b0;
        end else if (wr_i) begin
            pwr_q  <= wdata_i[CTL_PWR];
            run_q  <= wdata_i[CTL_RUN];
            auto_q <= wdata_i[CTL_AUTO];
        end else if (expire_i && !auto_q) begin
            run_q  <= 1'b0;
        end
    end

    // Sticky flag: set on expiry, cleared by writing one to its bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire_i) begin
            flag_q <= 1'b1;
        end else if (wr_i && wdata_i[CTL_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    assign pwr_o    = pwr_q;
    assign run_o    = run_q;
    assign autold_o = auto_q;
    assign flag_o   = flag_q;

    // R6: every expiry leaves the flag set.
    p_flag_on_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q);

    // R9: the flag survives unless a one is written to it.
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_i && wdata_i[CTL_FLAG])) |=> flag_q);

    // R8: a one-shot expiry with no control write stops the run bit.
    p_oneshot_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !auto_q && !wr_i) |=> !run_q);
endmodule

// File: rtl/prescaled_interval_timer.sv
// Top of the interval timer. It decodes the single-cycle register bus and
// holds the period and prescale registers. It wires the prescaler, count and
// control pieces together and returns read data combinationally. It assumes
// that one access is presented per cycle with bus_sel high.
module prescaled_interval_timer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import tmr_pkg::*;

    localparam int CTL_BITS = 4;

    reg_sel_e          sel;
    logic              hit, wr_ctrl, wr_period, wr_scale, wr_count;
    logic [DATA_W-1:0] period_q, scale_q, count_w;
    logic              pwr, run, autold, flag, active, tick, expire;

    // Decode: aligned accesses only; bits [3:2] pick the register.
    assign sel       = reg_sel_e'(bus_addr[3:2]);
    assign hit       = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_ctrl   = hit && bus_wr && (sel == SEL_CTRL);
    assign wr_period = hit && bus_wr && (sel == SEL_PERIOD);
    assign wr_scale  = hit && bus_wr && (sel == SEL_SCALE);
    assign wr_count  = hit && bus_wr && (sel == SEL_COUNT);

    // Period and prescale registers: plain storage written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            scale_q  <= '0;
        end else begin
            if (wr_period) period_q <= bus_wdata;
            if (wr_scale)  scale_q  <= bus_wdata;
        end
    end

    assign active = pwr && run;

    tmr_prescaler #(.W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .scale_i  (scale_q),
        .tick_o   (tick)
    );

    tmr_downcount #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (wr_count),
        .load_val_i (bus_wdata),
        .period_i   (period_q),
        .autold_i   (autold),
        .count_o    (count_w),
        .expire_o   (expire)
    );

    tmr_control u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_ctrl),
        .wdata_i  (bus_wdata[CTL_BITS-1:0]),
        .expire_i (expire),
        .pwr_o    (pwr),
        .run_o    (run),
        .autold_o (autold),
        .flag_o   (flag)
    );

    // Read mux: selected register, zero for misaligned addresses.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            case (sel)
                SEL_CTRL:   bus_rdata = {{(DATA_W-CTL_BITS){1'b0}}, flag, autold, run, pwr};
                SEL_PERIOD: bus_rdata = period_q;
                SEL_SCALE:  bus_rdata = scale_q;
                SEL_COUNT:  bus_rdata = count_w;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = flag;

    // R10: a control write of zero leaves the timer unable to tick next cycle.
    p_zero_ctrl_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && (bus_wdata[1:0] == 2'b00)) |=> !tick);
endmodule

// File: tb/prescaled_interval_timer_test.sv
`timescale 1ns/100ps
module prescaled_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_SCL = 4'h8, A_CNT = 4'hC;

    // Scenario table: scale, preload, period, control word, wait, exp count, exp control
    localparam int NV = 11;
    localparam logic [31:0] V_SCALE [NV] = '{0, 2, 0, 0, 0, 0, 2, 0, 0, 0, 0};
    localparam logic [31:0] V_LOAD  [NV] = '{10, 10, 5, 5, 3, 3, 32'h13, 2, 10, 10, 10};
    localparam logic [31:0] V_PER   [NV] = '{0, 0, 0, 0, 5, 5, 32'h15, 4, 0, 0, 0};
    localparam logic [31:0] V_CTRL  [NV] = '{3, 3, 3, 3, 7, 7, 7, 7, 1, 2, 5};
    localparam int          V_WAIT  [NV] = '{4, 9, 5, 8, 3, 5, 60, 6, 20, 20, 20};
    localparam logic [31:0] V_ECNT  [NV] = '{6, 7, 0, 0, 5, 3, 32'h14, 4, 10, 10, 10};
    localparam logic [31:0] V_ECTL  [NV] = '{3, 3, 9, 9, 15, 15, 15, 15, 1, 2, 5};

    prescaled_interval_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;

    // Called at a falling edge: the write lands on the next rising edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Combinational read; consumes no clock edge.
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] d;
        wait_edges(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_PER, d);  check("R1 period", d, 0);
        rd(A_SCL, d);  check("R1 scale", d, 0);
        rd(A_CNT, d);  check("R1 count", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // Table walk: R3 R4 R6 R7 R8 R12
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, 32'h8);
            wr(A_PER, V_PER[i]);
            wr(A_SCL, V_SCALE[i]);
            wr(A_CNT, V_LOAD[i]);
            wr(A_CTRL, V_CTRL[i]);
            wait_edges(V_WAIT[i]);
            rd(A_CNT, d);  check($sformatf("R4/R7/R8/R3 vec%0d count", i), d, V_ECNT[i]);
            rd(A_CTRL, d); check($sformatf("R12/R6/R8 vec%0d ctrl", i), d, V_ECTL[i]);
            check($sformatf("R6 vec%0d irq", i), {31'b0, irq}, {31'b0, V_ECTL[i][3]});
        end

        // R2: read-back and misaligned write ignored
        wr(A_CTRL, 32'h8);
        wr(A_PER, 32'h50);
        wr(A_SCL, 32'h7);
        wr(4'h5, 32'hDEAD);
        rd(A_PER, d); check("R2 period readback", d, 32'h50);
        rd(A_SCL, d); check("R2 scale readback", d, 32'h7);
        rd(4'h5, d);  check("R2 misaligned read", d, 0);

        // R9: flag held by a zero write, cleared by a one write
        wr(A_SCL, 0);
        wr(A_CNT, 1);
        wr(A_CTRL, 32'h3);
        wait_edges(2);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, d); check("R9 flag kept on zero write", d, 32'h9);
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, d); check("R9 flag cleared", d, 0);
        check("R9 irq low", {31'b0, irq}, 0);

        // R10: zero control write stops counting
        wr(A_CNT, 100);
        wr(A_CTRL, 32'h3);
        wait_edges(5);
        rd(A_CNT, d); check("R10 running", d, 95);
        wr(A_CTRL, 32'h0);
        wait_edges(10);
        rd(A_CNT, d); check("R10 held after stop", d, 94);

        // R11: count write while running overrides the decrement
        wr(A_CNT, 100);
        wr(A_CTRL, 32'h3);
        wait_edges(3);
        wr(A_CNT, 40);
        rd(A_CNT, d); check("R11 preload wins", d, 40);
        wait_edges(2);
        rd(A_CNT, d); check("R11 continues", d, 38);

        // R5: prescaler restarts from zero after a pause
        wr(A_CTRL, 32'h0);
        wr(A_SCL, 3);
        wr(A_CNT, 20);
        wr(A_CTRL, 32'h3);
        wait_edges(2);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h3);
        wait_edges(3);
        rd(A_CNT, d); check("R5 full interval after restart", d, 20);
        wait_edges(1);
        rd(A_CNT, d); check("R4 first step after S+1 edges", d, 19);

        summary();
    end
endmodule